// File: doc/BRIEF.md
# Interruptible Repeating Block-Copy Engine

This block moves a run of bytes from one memory region to another. It does this as a chain of single-byte steps. Software writes three registers: a remaining-byte count, a source pointer and a destination pointer. It then pulses `start`. Each step reads one byte at the source pointer and writes that byte at the destination pointer. After the write, both pointers move up by one and the count moves down by one. The step then re-arms itself, unless the count it has just produced is zero.

Because each byte is a complete step, the engine can halt at any step boundary when an interrupt request is pending. It signals `irq_ack` and holds its three registers frozen until the request is withdrawn. Then it continues with the next byte. The registers can always be read back, so progress is visible during a pause.

The state machine has six states:
- ST_IDLE: waiting for `start`.
- ST_READ: issues the read at the source pointer.
- ST_LATCH: captures the returned byte.
- ST_WRITE: writes the byte to the destination and updates the registers.
- ST_PAUSE: acknowledging an interrupt.
- ST_DONE: a one-cycle completion state.

Transitions:
- IDLE→READ on start.
- READ→LATCH and LATCH→WRITE always.
- WRITE→DONE when the step leaves a zero count.
- WRITE→PAUSE when the count is nonzero and `irq_req` is high.
- WRITE→READ otherwise.
- PAUSE→READ when `irq_req` falls.
- DONE→READ on start, otherwise DONE→IDLE.

Top module: `blkcopy_engine`

## Requirements
- R1: A synchronous reset sets the state to ST_IDLE and clears the count, source and destination registers. It also drives `busy`, `done`, `irq_ack`, `mem_re` and `mem_we` low.
- R2: While `busy` is low, `ld_cnt`, `ld_src` or `ld_dst` loads `ld_value` into its register. The new value shows on `cnt_q`, `src_q` or `dst_q` after the next clock edge.
- R3: Each step takes exactly three cycles. In the first cycle, `mem_re` is high and `mem_addr` equals the source pointer. In the third cycle, `mem_we` is high, `mem_addr` equals the destination pointer, and `mem_wdata` is the byte the memory returned one cycle after the read. `mem_re` and `mem_we` are never high together.
- R4: At the end of each step, source and destination each increase by one and the count decreases by one, all modulo 2^ADDR_W. A pointer at all ones therefore wraps to zero.
- R5: Steps repeat until a step leaves the count at zero. In the following cycle, `done` is high for exactly one cycle, `busy` is low and `cnt_q` is zero. `busy` is high from the cycle after an accepted start until then.
- R6: A start with a count of zero copies 2^ADDR_W bytes, because the count is tested only after each step. The count wraps to all ones after the first byte.
- R7: If `irq_req` is high at the end of a step that leaves a nonzero count, the engine enters ST_PAUSE with `irq_ack` high and all three registers unchanged. It resumes with the next byte in the cycle after `irq_req` falls, and no byte is lost or repeated.
- R8: The last step of a copy never pauses. A pending `irq_req` at that step does not delay `done`.
- R9: Load strobes have no effect while `busy` is high, including in ST_PAUSE.
- R10: `start` has no effect while `busy` is high. The copy in progress transfers exactly its original count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a copy with the current register contents |
| irq_req | input | 1 | Interrupt request, sampled at step ends |
| irq_ack | output | 1 | High while paused for an interrupt |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_cnt | input | 1 | Load count register |
| ld_src | input | 1 | Load source pointer |
| ld_dst | input | 1 | Load destination pointer |
| ld_value | input | ADDR_W | Value for the load strobes |
| cnt_q | output | ADDR_W | Current count |
| src_q | output | ADDR_W | Current source pointer |
| dst_q | output | ADDR_W | Current destination pointer |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after `mem_re` |

## Verification
The bench builds the engine with ADDR_W=8 and DATA_W=8. At that width a zero-count start sweeps the entire 256-byte space, and pointer wrap past all ones occurs in ordinary short copies. The bench keeps its own 256-byte memory and a forward byte-by-byte copy model. It sweeps many counts and pointer pairs, including overlapping regions. It checks memory contents, final register values and busy-cycle totals of three cycles per byte. A further run pauses at every byte boundary of a copy, trying loads and starts during each pause, and checks that the final byte never pauses.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_LATCH,
        ST_WRITE,
        ST_PAUSE,
        ST_DONE
    } bc_state_t;

    localparam int unsigned REG_CNT  = 0;
    localparam int unsigned REG_SRC  = 1;
    localparam int unsigned REG_DST  = 2;
    localparam int unsigned NUM_REGS = 3;

endpackage

// File: rtl/blkcopy_ptr.sv
module blkcopy_ptr #(
    parameter int W    = 16,
    parameter bit DOWN = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    input  logic         step,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] q_next;

    generate
        if (DOWN) begin : g_down
            assign q_next = q - ONE;
        end else begin : g_up
            assign q_next = q + ONE;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (step) begin
            q <= q_next;
        end else if (ld_en) begin
            q <= ld_val;
        end
    end

    generate
        if (DOWN) begin : g_chk_down
            AST_PTR_DEC: assert property (@(posedge clk) disable iff (rst)
                step |=> (q == $past(q) - ONE)); // R4
        end else begin : g_chk_up
            AST_PTR_INC: assert property (@(posedge clk) disable iff (rst)
                step |=> (q == $past(q) + ONE)); // R4
        end
    endgenerate

    AST_PTR_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step && !ld_en) |=> $stable(q)); // R9

endmodule

// File: rtl/blkcopy_xfer.sv
module blkcopy_xfer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              sel_dst,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (capture) begin
            hold_q <= rdata;
        end
    end

    always_comb begin
        addr  = sel_dst ? dst : src;
        wdata = hold_q;
    end

endmodule

// File: rtl/blkcopy_fsm.sv
module blkcopy_fsm
    import blkcopy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      irq_req,
    input  logic      last_step,
    output bc_state_t state,
    output logic      busy,
    output logic      done,
    output logic      irq_ack,
    output logic      mem_re,
    output logic      mem_we,
    output logic      capture,
    output logic      sel_dst,
    output logic      step
);
    bc_state_t state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start) state_n = ST_READ;
            ST_READ:  state_n = ST_LATCH;
            ST_LATCH: state_n = ST_WRITE;
            ST_WRITE: begin
                if (last_step)    state_n = ST_DONE;
                else if (irq_req) state_n = ST_PAUSE;
                else              state_n = ST_READ;
            end
            ST_PAUSE: if (!irq_req) state_n = ST_READ;
            ST_DONE:  state_n = start ? ST_READ : ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        irq_ack = 1'b0;
        mem_re  = 1'b0;
        mem_we  = 1'b0;
        capture = 1'b0;
        sel_dst = 1'b0;
        step    = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_READ:  begin busy = 1'b1; mem_re = 1'b1; end
            ST_LATCH: begin busy = 1'b1; capture = 1'b1; end
            ST_WRITE: begin
                busy    = 1'b1;
                mem_we  = 1'b1;
                sel_dst = 1'b1;
                step    = 1'b1;
            end
            ST_PAUSE: begin busy = 1'b1; irq_ack = 1'b1; end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we)); // R3
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> capture ##1 mem_we); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_ACK_MEANS_BUSY: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> busy); // R7
    AST_PAUSE_HELD: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=> irq_ack); // R7
    AST_LAST_NO_PAUSE: assert property (@(posedge clk) disable iff (rst)
        (mem_we && last_step) |=> (done && !irq_ack)); // R8

endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
    import blkcopy_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              irq_req,
    output logic              irq_ack,
    output logic              busy,
    output logic              done,
    input  logic              ld_cnt,
    input  logic              ld_src,
    input  logic              ld_dst,
    input  logic [ADDR_W-1:0] ld_value,
    output logic [ADDR_W-1:0] cnt_q,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam logic [ADDR_W-1:0] CNT_LAST = {{(ADDR_W-1){1'b0}}, 1'b1};

    bc_state_t         state;
    logic              capture;
    logic              sel_dst;
    logic              step;
    logic              last_step;
    logic [NUM_REGS-1:0] ld_vec;
    logic [ADDR_W-1:0] reg_q [NUM_REGS];

    always_comb begin
        ld_vec          = '0;
        ld_vec[REG_CNT] = ld_cnt & ~busy;
        ld_vec[REG_SRC] = ld_src & ~busy;
        ld_vec[REG_DST] = ld_dst & ~busy;
    end

    generate
        for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
            blkcopy_ptr #(
                .W   (ADDR_W),
                .DOWN(gi == REG_CNT)
            ) u_reg (
                .clk   (clk),
                .rst   (rst),
                .ld_en (ld_vec[gi]),
                .ld_val(ld_value),
                .step  (step),
                .q     (reg_q[gi])
            );
        end
    endgenerate

    assign cnt_q     = reg_q[REG_CNT];
    assign src_q     = reg_q[REG_SRC];
    assign dst_q     = reg_q[REG_DST];
    assign last_step = (cnt_q == CNT_LAST);

    blkcopy_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .irq_req  (irq_req),
        .last_step(last_step),
        .state    (state),
        .busy     (busy),
        .done     (done),
        .irq_ack  (irq_ack),
        .mem_re   (mem_re),
        .mem_we   (mem_we),
        .capture  (capture),
        .sel_dst  (sel_dst),
        .step     (step)
    );

    blkcopy_xfer #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_xfer (
        .clk    (clk),
        .rst    (rst),
        .capture(capture),
        .sel_dst(sel_dst),
        .src    (src_q),
        .dst    (dst_q),
        .rdata  (mem_rdata),
        .addr   (mem_addr),
        .wdata  (mem_wdata)
    );

    AST_READ_AT_SRC: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> (mem_addr == src_q)); // R3
    AST_WRITE_AT_DST: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == dst_q)); // R3
    AST_DONE_ZERO: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt_q == '0 && !busy)); // R5
    AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_we) |=> ($stable(cnt_q) && $stable(src_q) && $stable(dst_q))); // R9
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (mem_re && start) |=> (state == ST_LATCH)); // R10

endmodule

// File: tb/blkcopy_engine_bench.sv
module blkcopy_engine_bench;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int MEMSZ = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, irq_req = 1'b0;
    logic ld_cnt = 1'b0, ld_src = 1'b0, ld_dst = 1'b0;
    logic [AW-1:0] ld_value = '0;
    logic irq_ack, busy, done, mem_re, mem_we;
    logic [AW-1:0] cnt_q, src_q, dst_q, mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic [DW-1:0] mem [MEMSZ];
    logic [DW-1:0] model [MEMSZ];
    int tests = 0, fails = 0, writes = 0, cycles = 0;

    always #5 clk = ~clk;

    blkcopy_engine #(.ADDR_W(AW), .DATA_W(DW)) u_blkcopy_engine (
        .clk(clk), .rst(rst), .start(start), .irq_req(irq_req), .irq_ack(irq_ack),
        .busy(busy), .done(done), .ld_cnt(ld_cnt), .ld_src(ld_src), .ld_dst(ld_dst),
        .ld_value(ld_value), .cnt_q(cnt_q), .src_q(src_q), .dst_q(dst_q),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            writes <= writes + 1;
        end
        cycles <= cycles + 1;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            summary();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < MEMSZ; i++) begin
            mem[i]   = DW'((i * 7 + seed * 13 + 3) & 8'hFF);
            model[i] = mem[i];
        end
    endtask

    task automatic load(input logic [AW-1:0] c, input logic [AW-1:0] s, input logic [AW-1:0] d);
        @(negedge clk); ld_cnt = 1'b1; ld_value = c;
        @(negedge clk); ld_cnt = 1'b0; ld_src = 1'b1; ld_value = s;
        @(negedge clk); ld_src = 1'b0; ld_dst = 1'b1; ld_value = d;
        @(negedge clk); ld_dst = 1'b0;
    endtask

    task automatic model_copy(input int n, input logic [AW-1:0] s, input logic [AW-1:0] d);
        for (int i = 0; i < n; i++) model[AW'(d + i)] = model[AW'(s + i)];
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_copy(input string req, input int n_eff, input logic [AW-1:0] c,
                            input logic [AW-1:0] s, input logic [AW-1:0] d, input bit restart);
        int busy_cyc = 0;
        int w0;
        int bad = 0;
        load(c, s, d);
        model_copy(n_eff, s, d);
        w0 = writes;
        pulse_start();
        while (!done && busy_cyc < 4000) begin
            if (busy) busy_cyc++;
            if (restart && busy_cyc == 2) begin
                start = 1'b1; ld_cnt = 1'b1; ld_value = 8'h55;
            end else begin
                start = 1'b0; ld_cnt = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; ld_cnt = 1'b0;
        chk({req, " R3 cycles"}, busy_cyc, 3 * n_eff);
        chk({req, " R5 done busy low"}, int'(busy), 0);
        chk({req, " R5 cnt zero"}, int'(cnt_q), 0);
        chk({req, " R4 src end"}, int'(src_q), int'(AW'(s + n_eff)));
        chk({req, " R4 dst end"}, int'(dst_q), int'(AW'(d + n_eff)));
        chk({req, " R10 writes"}, writes - w0, n_eff);
        for (int i = 0; i < MEMSZ; i++) if (mem[i] !== model[i]) bad++;
        chk({req, " R3 memory"}, bad, 0);
        @(negedge clk);
        chk({req, " R5 done one cycle"}, int'(done), 0);
    endtask

    initial begin
        mem_rdata = '0;
        fill(1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 ack", int'(irq_ack), 0);
        chk("R1 mem enables", int'(mem_re | mem_we), 0);
        chk("R1 regs", int'(cnt_q | src_q | dst_q), 0);

        load(8'h21, 8'h43, 8'h65);
        chk("R2 cnt", int'(cnt_q), 8'h21);
        chk("R2 src", int'(src_q), 8'h43);
        chk("R2 dst", int'(dst_q), 8'h65);

        // sweep of counts and pointer pairs, including overlap and wrap (R4)
        for (int n = 1; n <= 20; n++) begin
            fill(n);
            run_copy("sweep", n, AW'(n), AW'(n * 37), AW'(n * 37 + 50 + n), 1'b0);
        end
        fill(30); run_copy("overlap fwd", 9, 8'd9, 8'h40, 8'h41, 1'b0);
        fill(31); run_copy("overlap back", 9, 8'd9, 8'h41, 8'h40, 1'b0);
        fill(32); run_copy("wrap R4", 12, 8'd12, 8'hFA, 8'hF6, 1'b0);
        fill(33); run_copy("restart R10", 7, 8'd7, 8'h10, 8'h90, 1'b1);
        fill(34); run_copy("zero count R6", MEMSZ, 8'd0, 8'h00, 8'h80, 1'b0);

        // pause at every byte boundary (R7, R8, R9)
        begin
            int n = 6;
            int pauses = 0;
            int w0;
            int bad = 0;
            logic [AW-1:0] s = 8'h30, d = 8'hA0;
            fill(40);
            load(AW'(n), s, d);
            model_copy(n, s, d);
            w0 = writes;
            irq_req = 1'b1;
            pulse_start();
            while (!done && cycles < 100000) begin
                if (irq_ack) begin
                    pauses++;
                    chk("R7 cnt held", int'(cnt_q), n - pauses);
                    chk("R7 src", int'(src_q), int'(AW'(s + pauses)));
                    chk("R7 dst", int'(dst_q), int'(AW'(d + pauses)));
                    chk("R7 writes", writes - w0, pauses);
                    ld_cnt = 1'b1; ld_src = 1'b1; ld_dst = 1'b1; ld_value = 8'hEE;
                    start = 1'b1;
                    repeat (4) @(negedge clk);
                    ld_cnt = 1'b0; ld_src = 1'b0; ld_dst = 1'b0; start = 1'b0;
                    chk("R9 cnt", int'(cnt_q), n - pauses);
                    chk("R9 src", int'(src_q), int'(AW'(s + pauses)));
                    chk("R7 ack held", int'(irq_ack), 1);
                    irq_req = 1'b0;
                    @(negedge clk);
                    chk("R7 resumed", int'(irq_ack), 0);
                    irq_req = 1'b1;
                end
                @(negedge clk);
            end
            irq_req = 1'b0;
            chk("R8 pause count", pauses, n - 1);
            chk("R8 done", int'(done), 1);
            chk("R7 total writes", writes - w0, n);
            for (int i = 0; i < MEMSZ; i++) if (mem[i] !== model[i]) bad++;
            chk("R7 memory", bad, 0);
        end

        // count of one with interrupt pending: no pause (R8)
        fill(50);
        irq_req = 1'b1;
        run_copy("single irq R8", 1, 8'd1, 8'h05, 8'h06, 1'b0);
        irq_req = 1'b0;

        summary();
    end
endmodule